// File: doc/BRIEF.md
# Dual-Window Overcurrent Discriminator

This block looks at a stream of current-magnitude samples and decides whether the load switch has to be opened. A single comparator cannot separate the short surge a load draws when it starts from a real overload. This block therefore runs three detectors side by side on the same qualified samples. A short peak window allows high current for a programmable number of consecutive samples. A long window smooths the current through a leaky average and compares it with a lower sustained limit, which must be exceeded for a programmable persistence count. A burst tracker counts how often the current newly rises above the peak limit within a rolling interval of samples.

Samples that arrive while the switch-event blanking input is high are ignored by all three detectors. A range-select input switches both limits between a low-current set and a high-current set. A trip controller owns the result. It has three states. MONITOR is entered from reset and from a clear. MONITOR goes to TRIP when any detector fires. TRIP lasts one cycle and always goes on to LATCHED. LATCHED returns to MONITOR only on an explicit clear. While the fault is held, the detectors are emptied. The cause of each trip is kept as a reason code, and a saturating counter per reason records how many trips occurred.

Top module: `ocp_discriminator`

## Requirements
- R1: After reset, fault, trip_req and trip_reason are 0, and all three trip counters are 0.
- R2: A qualified sample counts as over-peak when smp_mag is strictly greater than the selected peak limit. When the number of consecutive over-peak qualified samples reaches cfg_peak_run, the fault latches with reason 1. A value of 0 in cfg_peak_run is treated as 1. The fault is visible in the cycle after the clock edge that takes the deciding sample.
- R3: A run of over-peak samples shorter than cfg_peak_run does not trip. A qualified sample at or below the peak limit restarts the run.
- R4: On every qualified sample, the accumulator A is updated as A = A - (A >> 3) + smp_mag, and the average is A >> 3. While this average is strictly above the selected sustained limit for cfg_persist consecutive qualified samples, the fault latches with reason 2. A qualified sample whose average is not above the limit restarts the persistence count. A value of 0 in cfg_persist is treated as 1.
- R5: A sample with smp_blank high has no effect on any detector. It does not extend or restart the peak run, it does not change the average or the persistence count, and it does not start a burst. It does advance the burst interval.
- R6: With range_hi at 1, the detectors use cfg_peak_hi and cfg_sust_hi. With range_hi at 0, they use cfg_peak_lo and cfg_sust_lo.
- R7: A burst is a qualified over-peak sample whose previous qualified sample was not over-peak. The fault latches with reason 3 when a burst arrives and cfg_burst_max bursts have already occurred in the current interval. An interval consists of cfg_burst_win valid samples, and the burst count returns to zero at the end of each interval.
- R8: trip_req is high for exactly one cycle when the fault latches. The fault and the reason then hold, and fault_clr is ignored during that cycle. A later fault_clr returns fault and reason to 0 and restarts every detector from empty. Samples taken while the fault is held do not trip again.
- R9: When several detectors fire on the same sample, the reason is chosen in priority order: peak (1) first, then sustained (2), then burst (3).
- R10: cnt_peak, cnt_sust and cnt_burst each count the trips with reason 1, 2 and 3, and each saturates at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_mag | input | MAG_W | Current-magnitude sample |
| smp_blank | input | 1 | Switch-event blanking; the sample is ignored |
| range_hi | input | 1 | 1 selects the high-range limits |
| cfg_peak_lo | input | MAG_W | Peak limit, low range |
| cfg_peak_hi | input | MAG_W | Peak limit, high range |
| cfg_sust_lo | input | MAG_W | Sustained limit, low range |
| cfg_sust_hi | input | MAG_W | Sustained limit, high range |
| cfg_peak_run | input | RUN_W | Consecutive over-peak samples needed to trip |
| cfg_persist | input | PERS_W | Consecutive over-average samples needed to trip |
| cfg_burst_max | input | BURST_W | Bursts allowed per interval |
| cfg_burst_win | input | WIN_W | Interval length in valid samples |
| fault_clr | input | 1 | Clears a latched fault |
| fault | output | 1 | Latched fault |
| trip_req | output | 1 | One-cycle request to open the switch |
| trip_reason | output | 2 | 0 none, 1 peak, 2 sustained, 3 burst |
| cnt_peak | output | CNT_W | Peak trip count, saturating |
| cnt_sust | output | CNT_W | Sustained trip count, saturating |
| cnt_burst | output | CNT_W | Burst trip count, saturating |

## Verification
The hardest case to reach from the ports is the exact sample on which the sustained detector fires. That sample depends on the shifted running average and on a persistence count that restarts whenever the average dips. The bench keeps its own copy of the averaging arithmetic taken from R4. It feeds steady and square-wave current patterns and checks the fault after every sample. A second hard case is the burst interval boundary. The bench first forces a trip and a clear, which aligns the interval with its own sample count. It then places exactly the allowed number of bursts in each of several intervals before exceeding the limit inside one interval.

// File: rtl/ocd_pkg.sv
package ocd_pkg;

    typedef enum logic [1:0] {
        RSN_NONE  = 2'd0,
        RSN_PEAK  = 2'd1,
        RSN_SUST  = 2'd2,
        RSN_BURST = 2'd3
    } reason_e;

    typedef enum logic [1:0] {
        ST_MONITOR = 2'd0,
        ST_TRIP    = 2'd1,
        ST_LATCHED = 2'd2
    } trip_state_e;

endpackage

// File: rtl/ocd_peak_det.sv
module ocd_peak_det #(
    parameter int MAG_W = 12,
    parameter int RUN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             smp_valid,
    input  logic             smp_blank,
    input  logic [MAG_W-1:0] smp_mag,
    input  logic [MAG_W-1:0] limit,
    input  logic [RUN_W-1:0] need,
    output logic             over,
    output logic             hit
);
    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] need_eff;
    logic             qual;

    assign qual     = smp_valid && !smp_blank && !flush;
    assign over     = smp_mag > limit;
    assign need_eff = (need == '0) ? RUN_W'(1) : need;
    assign hit      = qual && over && (({1'b0, run_q} + 1'b1) >= {1'b0, need_eff});

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            run_q <= '0;
        end else if (qual) begin
            if (over) begin
                if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
            end else begin
                run_q <= '0;
            end
        end
    end

    // R5: a blanked sample leaves the peak run untouched
    assert_blank_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_blank && !flush) |=> $stable(run_q));

    // R3: a qualified sample at or below the limit restarts the run
    assert_run_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && !over) |=> (run_q == '0));

endmodule

// File: rtl/ocd_sust_det.sv
module ocd_sust_det #(
    parameter int MAG_W  = 12,
    parameter int SHIFT  = 3,
    parameter int PERS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              smp_valid,
    input  logic              smp_blank,
    input  logic [MAG_W-1:0]  smp_mag,
    input  logic [MAG_W-1:0]  limit,
    input  logic [PERS_W-1:0] need,
    output logic              hit
);
    localparam int ACC_W = MAG_W + SHIFT;
    localparam logic [PERS_W-1:0] PERS_MAX = {PERS_W{1'b1}};

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  acc_next;
    logic [PERS_W-1:0] pers_q;
    logic [PERS_W-1:0] need_eff;
    logic              qual;
    logic              above;

    assign qual     = smp_valid && !smp_blank && !flush;
    assign acc_next = acc_q - (acc_q >> SHIFT) + ACC_W'(smp_mag);
    // average (acc_next >> SHIFT) strictly greater than limit
    assign above    = acc_next > {limit, {SHIFT{1'b1}}};
    assign need_eff = (need == '0) ? PERS_W'(1) : need;
    assign hit      = qual && above && (({1'b0, pers_q} + 1'b1) >= {1'b0, need_eff});

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            acc_q  <= '0;
            pers_q <= '0;
        end else if (qual) begin
            acc_q <= acc_next;
            if (above) begin
                if (pers_q != PERS_MAX) pers_q <= pers_q + 1'b1;
            end else begin
                pers_q <= '0;
            end
        end
    end

    // R5: blanked samples do not enter the running average
    assert_blank_avg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_blank && !flush) |=> ($stable(acc_q) && $stable(pers_q)));

    // R8: while the fault is held the long window stays empty
    assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (acc_q == '0));

endmodule

// File: rtl/ocd_burst_det.sv
module ocd_burst_det #(
    parameter int BURST_W = 6,
    parameter int WIN_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               smp_valid,
    input  logic               smp_blank,
    input  logic               over,
    input  logic [BURST_W-1:0] max_bursts,
    input  logic [WIN_W-1:0]   win_len,
    output logic               hit
);
    localparam logic [BURST_W-1:0] BURST_SAT = {BURST_W{1'b1}};

    logic [WIN_W-1:0]   wcnt_q;
    logic [BURST_W-1:0] bcnt_q;
    logic               prev_q;
    logic               qual;
    logic               start;
    logic               last;

    assign qual  = smp_valid && !smp_blank && !flush;
    assign start = qual && over && !prev_q;
    assign last  = (win_len == '0) || (wcnt_q >= (win_len - 1'b1));
    assign hit   = start && (bcnt_q >= max_bursts);

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wcnt_q <= '0;
            bcnt_q <= '0;
            prev_q <= 1'b0;
        end else if (smp_valid) begin
            if (qual) prev_q <= over;
            if (last) begin
                wcnt_q <= '0;
                bcnt_q <= '0;
            end else begin
                wcnt_q <= wcnt_q + 1'b1;
                if (start && bcnt_q != BURST_SAT) bcnt_q <= bcnt_q + 1'b1;
            end
        end
    end

    // R7: the burst count is empty after the last sample of an interval
    assert_interval_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !flush && last) |=> (bcnt_q == '0));

    // R5: a blanked sample cannot open a burst
    assert_blank_no_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_blank && !flush) |=> $stable(prev_q));

endmodule

// File: rtl/ocd_trip_fsm.sv
module ocd_trip_fsm
    import ocd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hit_peak,
    input  logic    hit_sust,
    input  logic    hit_burst,
    input  logic    fault_clr,
    output logic    fault,
    output logic    trip_req,
    output reason_e reason
);
    trip_state_e state_q, state_d;
    reason_e     reason_q, cause;
    logic        any_hit;

    assign any_hit = hit_peak || hit_sust || hit_burst;

    always_comb begin
        if (hit_peak)      cause = RSN_PEAK;
        else if (hit_sust) cause = RSN_SUST;
        else if (hit_burst) cause = RSN_BURST;
        else               cause = RSN_NONE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MONITOR: if (any_hit)   state_d = ST_TRIP;
            ST_TRIP:                   state_d = ST_LATCHED;
            ST_LATCHED: if (fault_clr) state_d = ST_MONITOR;
            default:                   state_d = ST_MONITOR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_MONITOR;
            reason_q <= RSN_NONE;
        end else begin
            state_q <= state_d;
            if (state_q == ST_MONITOR && any_hit)
                reason_q <= cause;
            else if (state_q == ST_LATCHED && fault_clr)
                reason_q <= RSN_NONE;
        end
    end

    always_comb begin
        fault    = (state_q != ST_MONITOR);
        trip_req = (state_q == ST_TRIP);
        reason   = reason_q;
    end

    // R8: the request to open the switch is a single-cycle pulse
    assert_trip_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trip_req |=> !trip_req);

    // R8: without a clear the fault holds
    assert_fault_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !fault_clr) |=> fault);

    // R9: a held fault always carries a cause, an idle block none
    assert_reason_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (reason != RSN_NONE));

    assert_reason_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> (reason == RSN_NONE));

endmodule

// File: rtl/ocp_discriminator.sv
module ocp_discriminator
    import ocd_pkg::*;
#(
    parameter int MAG_W     = 12,
    parameter int RUN_W     = 6,
    parameter int AVG_SHIFT = 3,
    parameter int PERS_W    = 8,
    parameter int BURST_W   = 6,
    parameter int WIN_W     = 10,
    parameter int CNT_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid,
    input  logic [MAG_W-1:0]   smp_mag,
    input  logic               smp_blank,
    input  logic               range_hi,
    input  logic [MAG_W-1:0]   cfg_peak_lo,
    input  logic [MAG_W-1:0]   cfg_peak_hi,
    input  logic [MAG_W-1:0]   cfg_sust_lo,
    input  logic [MAG_W-1:0]   cfg_sust_hi,
    input  logic [RUN_W-1:0]   cfg_peak_run,
    input  logic [PERS_W-1:0]  cfg_persist,
    input  logic [BURST_W-1:0] cfg_burst_max,
    input  logic [WIN_W-1:0]   cfg_burst_win,
    input  logic               fault_clr,
    output logic               fault,
    output logic               trip_req,
    output logic [1:0]         trip_reason,
    output logic [CNT_W-1:0]   cnt_peak,
    output logic [CNT_W-1:0]   cnt_sust,
    output logic [CNT_W-1:0]   cnt_burst
);
    localparam int N_RSN = 3;
    localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

    logic [MAG_W-1:0] peak_lim, sust_lim;
    logic             over, hit_peak, hit_sust, hit_burst;
    reason_e          reason;
    logic [CNT_W-1:0] cnt_q [N_RSN];

    assign peak_lim = range_hi ? cfg_peak_hi : cfg_peak_lo;
    assign sust_lim = range_hi ? cfg_sust_hi : cfg_sust_lo;

    ocd_peak_det #(.MAG_W(MAG_W), .RUN_W(RUN_W)) u_peak (
        .clk(clk), .rst_n(rst_n), .flush(fault),
        .smp_valid(smp_valid), .smp_blank(smp_blank), .smp_mag(smp_mag),
        .limit(peak_lim), .need(cfg_peak_run), .over(over), .hit(hit_peak)
    );

    ocd_sust_det #(.MAG_W(MAG_W), .SHIFT(AVG_SHIFT), .PERS_W(PERS_W)) u_sust (
        .clk(clk), .rst_n(rst_n), .flush(fault),
        .smp_valid(smp_valid), .smp_blank(smp_blank), .smp_mag(smp_mag),
        .limit(sust_lim), .need(cfg_persist), .hit(hit_sust)
    );

    ocd_burst_det #(.BURST_W(BURST_W), .WIN_W(WIN_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .flush(fault),
        .smp_valid(smp_valid), .smp_blank(smp_blank), .over(over),
        .max_bursts(cfg_burst_max), .win_len(cfg_burst_win), .hit(hit_burst)
    );

    ocd_trip_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .hit_peak(hit_peak), .hit_sust(hit_sust), .hit_burst(hit_burst),
        .fault_clr(fault_clr), .fault(fault), .trip_req(trip_req), .reason(reason)
    );

    assign trip_reason = reason;

    for (genvar g = 0; g < N_RSN; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q[g] <= '0;
            else if (trip_req && trip_reason == 2'(g + 1) && cnt_q[g] != CNT_SAT)
                cnt_q[g] <= cnt_q[g] + 1'b1;
        end

        // R10: trip counters never move backwards
        assert_cnt_mono_R10: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (cnt_q[g] >= $past(cnt_q[g])));
    end

    assign cnt_peak  = cnt_q[0];
    assign cnt_sust  = cnt_q[1];
    assign cnt_burst = cnt_q[2];

endmodule

// File: tb/tb_ocp_discriminator.sv
`timescale 1ns/1ps
module tb_ocp_discriminator;
    localparam int MAG_W = 12, RUN_W = 6, PERS_W = 8, BURST_W = 6, WIN_W = 10, CNT_W = 8;
    localparam int SAT = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0, smp_blank = 1'b0, range_hi = 1'b0, fault_clr = 1'b0;
    logic [MAG_W-1:0] smp_mag = '0;
    logic [MAG_W-1:0] cfg_peak_lo, cfg_peak_hi, cfg_sust_lo, cfg_sust_hi;
    logic [RUN_W-1:0] cfg_peak_run;
    logic [PERS_W-1:0] cfg_persist;
    logic [BURST_W-1:0] cfg_burst_max;
    logic [WIN_W-1:0] cfg_burst_win;
    logic fault, trip_req;
    logic [1:0] trip_reason;
    logic [CNT_W-1:0] cnt_peak, cnt_sust, cnt_burst;

    int n_chk = 0, n_bad = 0;
    int exp_pk = 0, exp_su = 0, exp_bu = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ocp_discriminator dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_mag(smp_mag),
        .smp_blank(smp_blank), .range_hi(range_hi),
        .cfg_peak_lo(cfg_peak_lo), .cfg_peak_hi(cfg_peak_hi),
        .cfg_sust_lo(cfg_sust_lo), .cfg_sust_hi(cfg_sust_hi),
        .cfg_peak_run(cfg_peak_run), .cfg_persist(cfg_persist),
        .cfg_burst_max(cfg_burst_max), .cfg_burst_win(cfg_burst_win),
        .fault_clr(fault_clr), .fault(fault), .trip_req(trip_req),
        .trip_reason(trip_reason), .cnt_peak(cnt_peak), .cnt_sust(cnt_sust),
        .cnt_burst(cnt_burst)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req, input int f, input int t, input int r);
        check(req, "fault", int'(fault), f);
        check(req, "trip_req", int'(trip_req), t);
        check(req, "reason", int'(trip_reason), r);
    endtask

    task automatic check_counts(input string req);
        check(req, "cnt_peak", int'(cnt_peak), exp_pk);
        check(req, "cnt_sust", int'(cnt_sust), exp_su);
        check(req, "cnt_burst", int'(cnt_burst), exp_bu);
    endtask

    task automatic send(input int mag, input bit blk);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_mag   = MAG_W'(mag);
        smp_blank = blk;
        @(negedge clk);
        smp_valid = 1'b0;
        smp_blank = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
    endtask

    task automatic cfg_default();
        range_hi      = 1'b0;
        cfg_peak_lo   = 12'd400;
        cfg_peak_hi   = 12'd1200;
        cfg_sust_lo   = 12'd4000;
        cfg_sust_hi   = 12'd4000;
        cfg_peak_run  = 6'd3;
        cfg_persist   = 8'd4;
        cfg_burst_max = 6'd63;
        cfg_burst_win = 10'd1000;
    endtask

    // force a peak trip and clear it so every detector starts empty
    task automatic flush_detectors();
        cfg_peak_run = 6'd1;
        send(1000, 1'b0);
        if (exp_pk < SAT) exp_pk++;
        clear();
        cfg_default();
    endtask

    task automatic t_reset();
        check_state("R1", 0, 0, 0);
        check_counts("R1");
    endtask

    task automatic t_peak();
        cfg_default();
        send(500, 0); send(500, 0);
        check_state("R3", 0, 0, 0);
        send(100, 0);
        send(500, 0); send(500, 0);
        check_state("R3", 0, 0, 0);
        send(500, 0);
        check_state("R2", 1, 1, 1);
        if (exp_pk < SAT) exp_pk++;
        @(negedge clk);
        check_state("R8", 1, 0, 1);
        clear();
        check_state("R8", 0, 0, 0);
        check_counts("R2");
    endtask

    task automatic t_blank();
        cfg_default();
        send(500, 0); send(100, 1); send(500, 0);
        check_state("R5", 0, 0, 0);
        send(500, 1);
        check_state("R5", 0, 0, 0);
        send(500, 0);
        check_state("R5", 1, 1, 1);
        if (exp_pk < SAT) exp_pk++;
        clear();
        cfg_peak_run = 6'd1; cfg_sust_lo = 12'd10; cfg_persist = 8'd1; cfg_burst_max = 6'd0;
        for (int i = 0; i < 20; i++) send(4000, 1);
        check_state("R5", 0, 0, 0);
        send(5, 0);
        check_state("R5", 0, 0, 0);
        check_counts("R5");
        cfg_default();
    endtask

    task automatic t_range();
        cfg_default();
        cfg_peak_run = 6'd1;
        range_hi = 1'b1;
        send(800, 0);
        check_state("R6", 0, 0, 0);
        range_hi = 1'b0;
        send(800, 0);
        check_state("R6", 1, 1, 1);
        if (exp_pk < SAT) exp_pk++;
        clear();
        range_hi = 1'b1;
        send(1300, 0);
        check_state("R6", 1, 1, 1);
        if (exp_pk < SAT) exp_pk++;
        clear();
        cfg_default();
    endtask

    // mode 0: constant 200; mode 1: constant 160; mode 2: 10 high / 10 zero square
    task automatic t_sust(input int mode, input int lim, input bit rng, input int pers, input int n);
        int acc = 0, pc = 0;
        bit tripped = 0;
        flush_detectors();
        cfg_peak_lo = 12'd4095; cfg_peak_hi = 12'd4095;
        cfg_sust_lo = 12'd4000; cfg_sust_hi = 12'd4000;
        if (rng) cfg_sust_hi = MAG_W'(lim); else cfg_sust_lo = MAG_W'(lim);
        range_hi = rng;
        cfg_persist = PERS_W'(pers);
        for (int i = 0; i < n && !tripped; i++) begin
            int s;
            bit above;
            s = (mode == 0) ? 200 : (mode == 1) ? 160 : (((i / 10) % 2) == 0 ? 250 : 0);
            acc = acc - (acc >> 3) + s;
            above = (acc >> 3) > lim;
            pc = above ? pc + 1 : 0;
            send(s, 0);
            if (above && pc >= pers) begin
                tripped = 1;
                check_state("R4", 1, 1, 2);
                if (exp_su < SAT) exp_su++;
            end else begin
                check_state("R4", 0, 0, 0);
            end
        end
        if (tripped) clear();
        check_counts("R4");
        cfg_default();
    endtask

    task automatic t_burst();
        flush_detectors();
        cfg_burst_max = 6'd2;
        cfg_burst_win = 10'd8;
        for (int w = 0; w < 3; w++) begin
            send(500, 0); send(100, 0); send(500, 0);
            for (int k = 0; k < 5; k++) send(100, 0);
            check_state("R7", 0, 0, 0);
        end
        send(500, 0); send(100, 0); send(500, 0); send(100, 0);
        check_state("R7", 0, 0, 0);
        send(500, 0);
        check_state("R7", 1, 1, 3);
        if (exp_bu < SAT) exp_bu++;
        clear();
        check_counts("R7");
        cfg_default();
    endtask

    task automatic t_priority();
        cfg_default();
        cfg_peak_run = 6'd1; cfg_peak_lo = 12'd50; cfg_sust_lo = 12'd0;
        cfg_persist = 8'd1; cfg_burst_max = 6'd0;
        send(1000, 0);
        check_state("R9", 1, 1, 1);
        if (exp_pk < SAT) exp_pk++;
        clear();
        cfg_peak_run = 6'd4;
        send(1000, 0);
        check_state("R9", 1, 1, 2);
        if (exp_su < SAT) exp_su++;
        clear();
        cfg_sust_lo = 12'd4095;
        send(1000, 0);
        check_state("R9", 1, 1, 3);
        if (exp_bu < SAT) exp_bu++;
        clear();
        check_counts("R9");
        cfg_default();
    endtask

    task automatic t_latch();
        cfg_default();
        cfg_peak_run = 6'd1;
        send(1000, 0);
        check_state("R8", 1, 1, 1);
        if (exp_pk < SAT) exp_pk++;
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        check_state("R8", 1, 0, 1);
        send(2000, 0);
        repeat (4) @(negedge clk);
        check_state("R8", 1, 0, 1);
        check_counts("R8");
        clear();
        check_state("R8", 0, 0, 0);
        cfg_peak_run = 6'd2;
        send(1000, 0);
        check_state("R8", 0, 0, 0);
        send(100, 0);
        cfg_default();
    endtask

    task automatic t_counters();
        check_counts("R10");
        cfg_default();
        cfg_peak_run = 6'd1;
        for (int i = 0; i < 260; i++) begin
            send(1000, 0);
            if (exp_pk < SAT) exp_pk++;
            clear();
        end
        check("R10", "cnt_peak saturated", int'(cnt_peak), SAT);
        check_counts("R10");
        cfg_default();
    endtask

    initial begin
        cfg_default();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_peak();
        t_blank();
        t_range();
        t_sust(0, 100, 1'b0, 4, 60);
        t_sust(1, 150, 1'b1, 4, 80);
        t_sust(2, 100, 1'b0, 12, 60);
        t_sust(2, 100, 1'b0, 3, 60);
        t_burst();
        t_priority();
        t_latch();
        t_counters();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule